// File: doc/BRIEF.md
# Oversampled Serial Line Transceiver

This block pairs a frame transmitter with a frame receiver for a shared single-wire serial line. Several nodes connect to the line, and each node runs on its own clock, which may differ slightly from the others. The line carries the AND of every node's output, so 1 is the idle (recessive) level and any node that drives 0 wins. The transmitter accepts a parallel word over a valid/ready handshake. It sends a 0 start bit, then the data bits LSB first, then a 1 stop bit, and it holds every bit cell for `CELL_CYC` of its own cycles. When it is disabled or idle, its output register sits at 1.

The receiver brings the line into the local clock domain through a synchronizer chain. It treats every 1-to-0 transition as the start of a fresh bit cell and samples each cell at a fixed position after the last such transition. This realignment keeps the result correct when individual cells appear one cycle short or one cycle long, which happens when the synchronizer resolves an edge one cycle late.

Input stream rules: a word transfers on a rising edge where `tx_valid` and `tx_ready` are both high. The source must hold `tx_valid` and `tx_data` steady until that edge. The line cannot be stalled, so the output side has no ready signal. `rx_valid` is a one-cycle strobe, and `rx_data` keeps its value until the next good frame.

Top module: `sbi_xcvr`

## Requirements
- R1: While `rst_n` is low, and directly after reset: `txd` is 1, `tx_busy`, `tx_done`, `tx_ready`, `rx_valid` and `rx_err` are 0, and `rx_data` is 0.
- R2: An accepted word appears on `txd` starting at the accepting edge, in this order: one 0 start cell, `DATA_W` data cells with bit 0 first, and one 1 stop cell. Each cell holds its value for exactly `CELL_CYC` (8) cycles.
- R3: `tx_ready` is high only when `tx_en` is high, no frame is in progress, and at least `GAP_CYC` (8) idle cycles have passed since reset, since the last frame ended, or since `tx_en` returned. A word offered while `tx_ready` is low stays pending.
- R4: While `tx_en` is low, `txd` is 1, no word is accepted, and any frame in progress is dropped from the next edge on.
- R5: `tx_busy` is high from the accepting edge until the end of the stop cell. At that point `tx_done` is high for exactly one cycle and `tx_busy` falls.
- R6: The receiver decodes frames correctly when each line transition arrives 0 or 1 cycle late, so that individual cells last 7, 8 or 9 cycles.
- R7: Each synchronized 1-to-0 transition restarts the receiver's cell timing. A bit is sampled `SAMPLE_POS` (4) cycles after the last transition, or a whole number of cells after it. The error therefore never adds up across cells.
- R8: A frame whose stop sample is 1 produces a one-cycle `rx_valid`, with the word on `rx_data` in the same cycle. `rx_data` changes at no other time.
- R9: A frame whose stop sample is 0 produces a one-cycle `rx_err`, no `rx_valid`, and leaves `rx_data` unchanged.
- R10: A low pulse shorter than `SAMPLE_POS` cycles reads as a 1 at the start sample. It produces no output, and the next frame decodes normally.
- R11: The node's own `txd`, fed back through the wired-AND line to `rxd`, is decoded to the word that was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmitter enable |
| tx_valid | input | 1 | Word offered for transmission |
| tx_ready | output | 1 | Transmitter can take a word |
| tx_data | input | DATA_W | Word to send |
| tx_busy | output | 1 | Frame in progress |
| tx_done | output | 1 | One-cycle strobe at end of stop cell |
| txd | output | 1 | Registered serial output to the line |
| rxd | input | 1 | Serial line value (AND of all nodes) |
| rx_valid | output | 1 | One-cycle strobe: good frame received |
| rx_data | output | DATA_W | Last good received word, held |
| rx_err | output | 1 | One-cycle strobe: stop bit read as 0 |

## Verification
`txd` takes the start value at the same edge that accepts the word. `tx_done` rises `CELL_CYC*(DATA_W+2)` edges later, and `tx_ready` returns `GAP_CYC` edges after that. The bench samples `txd` on every falling edge for every cell, and checks the done and ready timing at exactly those counts. On the receive side, a result appears about `2 + CELL_CYC*(DATA_W+1) + SAMPLE_POS` cycles after the first low reaches `rxd`, give or take the one-cycle edge jitter. Because that position moves with the jitter, the bench queues each expected word when it starts the frame. A monitor then pops the queue whenever a strobe appears, and any strobe with nothing queued counts as a miscompare.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  typedef enum logic { TX_IDLE = 1'b0, TX_SEND = 1'b1 } tx_state_t;
  typedef enum logic { RX_IDLE = 1'b0, RX_BUSY = 1'b1 } rx_state_t;
endpackage

// File: rtl/sbi_sync.sv
module sbi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= d_async;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sbi_tx.sv
module sbi_tx
  import sbi_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CELL_CYC = 8,
  parameter int GAP_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              busy,
  output logic              done,
  output logic              line_o
);
  localparam int CC_W  = (CELL_CYC > 1) ? $clog2(CELL_CYC) : 1;
  localparam int BI_W  = $clog2(DATA_W + 2);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [CC_W-1:0]  CC_LAST  = CC_W'(CELL_CYC - 1);
  localparam logic [BI_W-1:0]  BI_LAST  = BI_W'(DATA_W + 1);
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(GAP_CYC);

  tx_state_t         st;
  logic [CC_W-1:0]   cell_cnt;
  logic [BI_W-1:0]   bit_idx;
  logic [DATA_W:0]   shreg;
  logic [GAP_W-1:0]  gap_cnt;
  logic              take;

  assign in_ready = en && (st == TX_IDLE) && (gap_cnt == GAP_FULL);
  assign take     = in_valid && in_ready;
  assign busy     = (st == TX_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      cell_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= '1;
      gap_cnt  <= '0;
      line_o   <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st      <= TX_IDLE;
        line_o  <= 1'b1;
        gap_cnt <= '0;
      end else if (st == TX_IDLE) begin
        line_o <= 1'b1;
        if (take) begin
          st       <= TX_SEND;
          shreg    <= {1'b1, in_data};
          line_o   <= 1'b0;
          cell_cnt <= '0;
          bit_idx  <= '0;
          gap_cnt  <= '0;
        end else if (gap_cnt != GAP_FULL) begin
          gap_cnt <= gap_cnt + 1'b1;
        end
      end else begin
        if (cell_cnt == CC_LAST) begin
          cell_cnt <= '0;
          if (bit_idx == BI_LAST) begin
            st     <= TX_IDLE;
            line_o <= 1'b1;
            done   <= 1'b1;
          end else begin
            line_o  <= shreg[0];
            shreg   <= {1'b1, shreg[DATA_W:1]};
            bit_idx <= bit_idx + 1'b1;
          end
        end else begin
          cell_cnt <= cell_cnt + 1'b1;
        end
      end
    end
  end

  // R2: the output cannot move inside a bit cell
  a_r2_cell_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cell_cnt != '0) |-> $stable(line_o));
  // R4: disabled transmitter drives the recessive level
  a_r4_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> line_o);
  // R3: ready only while no frame is in progress
  a_r3_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !busy);
  // R5: done is a single-cycle strobe
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/sbi_rx.sv
module sbi_rx
  import sbi_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_CYC   = 8,
  parameter int SAMPLE_POS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_s,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err
);
  localparam int CC_W = (CELL_CYC > 1) ? $clog2(CELL_CYC) : 1;
  localparam int BI_W = $clog2(DATA_W + 2);
  localparam logic [CC_W-1:0] CC_LAST = CC_W'(CELL_CYC - 1);
  localparam logic [CC_W-1:0] CC_SMP  = CC_W'(SAMPLE_POS);
  localparam logic [BI_W-1:0] BI_STOP = BI_W'(DATA_W + 1);

  rx_state_t         st;
  logic              line_d;
  logic              fall;
  logic              smp;
  logic [CC_W-1:0]   pos;
  logic [BI_W-1:0]   bit_idx;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W:0]   sh_in;

  assign fall  = line_d && !line_s;
  assign smp   = (st == RX_BUSY) && !fall && (pos == CC_SMP);
  assign sh_in = {line_s, shreg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      line_d    <= 1'b1;
      pos       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else begin
      line_d    <= line_s;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      if (fall)                pos <= CC_W'(1);
      else if (pos == CC_LAST) pos <= '0;
      else                     pos <= pos + 1'b1;

      if (st == RX_IDLE) begin
        if (fall) begin
          st      <= RX_BUSY;
          bit_idx <= '0;
        end
      end else if (smp) begin
        if (bit_idx == '0) begin
          if (line_s) st <= RX_IDLE;
          else        bit_idx <= bit_idx + 1'b1;
        end else if (bit_idx == BI_STOP) begin
          st <= RX_IDLE;
          if (line_s) begin
            out_valid <= 1'b1;
            out_data  <= shreg;
          end else begin
            out_err <= 1'b1;
          end
        end else begin
          shreg   <= sh_in[DATA_W:1];
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  // R8: result strobe lasts one cycle
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R8: held word moves only alongside the strobe
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_data != $past(out_data)) |-> out_valid);
  // R9: error and good-frame strobes never coincide
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err));
  // R7: a synchronized falling edge always finds the cell timer running or restarts it
  a_r7_realign: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (pos == CC_W'(1)));
endmodule

// File: rtl/sbi_xcvr.sv
module sbi_xcvr #(
  parameter int DATA_W      = 8,
  parameter int CELL_CYC    = 8,
  parameter int SAMPLE_POS  = 4,
  parameter int GAP_CYC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              txd,
  input  logic              rxd,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_err
);
  logic rxd_s;

  sbi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rxd), .q_sync(rxd_s)
  );

  sbi_tx #(.DATA_W(DATA_W), .CELL_CYC(CELL_CYC), .GAP_CYC(GAP_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .in_valid(tx_valid),
    .in_ready(tx_ready), .in_data(tx_data), .busy(tx_busy),
    .done(tx_done), .line_o(txd)
  );

  sbi_rx #(.DATA_W(DATA_W), .CELL_CYC(CELL_CYC), .SAMPLE_POS(SAMPLE_POS)) u_rx (
    .clk(clk), .rst_n(rst_n), .line_s(rxd_s), .out_valid(rx_valid),
    .out_data(rx_data), .out_err(rx_err)
  );
endmodule

// File: tb/sbi_xcvr_bench.sv
module sbi_xcvr_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic tx_valid = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic drv = 1'b1;
  logic tx_ready, tx_busy, tx_done, txd, rx_valid, rx_err;
  logic [DW-1:0] rx_data;
  logic line;

  int checks = 0;
  int fails = 0;
  int events = 0;
  logic [DW:0] exp_q[$];
  logic [DW-1:0] last_good = '0;

  assign line = txd & drv;

  always #10 clk = ~clk;

  sbi_xcvr u_sbi_xcvr (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_busy(tx_busy),
    .tx_done(tx_done), .txd(txd), .rxd(line), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_err(rx_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected results as strobes appear
  always @(negedge clk) begin
    if (rst_n && (rx_valid || rx_err)) begin
      events++;
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected strobe", {rx_err, rx_data}, 0);
      end else begin
        logic [DW:0] e;
        e = exp_q.pop_front();
        if (e[DW]) begin
          chk(rx_err && !rx_valid && rx_data == last_good, "R9 stop error",
              {rx_err, rx_data}, {1'b1, last_good});
        end else begin
          chk(rx_valid && !rx_err && rx_data == e[DW-1:0], "R6 R11 decoded word",
              {rx_err, rx_data}, {1'b0, e[DW-1:0]});
          last_good = e[DW-1:0];
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // send through own transmitter, checking every cell on txd
  task automatic send_tx(input logic [DW-1:0] d);
    logic [DW+1:0] bits;
    int bad;
    bits = {1'b1, d, 1'b0};
    exp_q.push_back({1'b0, d});
    tx_data = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_busy == 1'b1, "R5 busy after accept", tx_busy, 1);
    for (int k = 0; k < DW + 2; k++) begin
      bad = 0;
      for (int c = 0; c < 8; c++) begin
        if (txd !== bits[k]) bad++;
        if (k == DW + 1 && c == 7) begin
          chk(!tx_done && tx_busy, "R5 busy through stop cell", tx_done, 0);
        end
        @(negedge clk);
      end
      chk(bad == 0, "R2 cell value and length", bad, 0);
    end
    chk(tx_done && !tx_busy, "R5 done strobe", {tx_done, tx_busy}, 2);
    @(negedge clk);
    chk(!tx_done, "R5 done one cycle", tx_done, 0);
    begin
      int n;
      n = 1;
      while (!tx_ready && n < 40) begin
        @(negedge clk);
        n++;
      end
      chk(n == 8, "R3 idle gap before ready", n, 8);
    end
  endtask

  // drive a frame on the line with per-transition jitter of 0 or 1 cycle
  task automatic drive_frame(input logic [DW-1:0] d, input logic [DW+2:0] jit, input logic stop_v);
    logic [DW+1:0] bits;
    int len;
    bits = {stop_v, d, 1'b0};
    exp_q.push_back(stop_v ? {1'b0, d} : {1'b1, {DW{1'b0}}});
    wait_cyc(int'(jit[0]));
    for (int k = 0; k < DW + 2; k++) begin
      len = 8 + int'(jit[k+1]) - int'(jit[k]);
      drv = bits[k];
      wait_cyc(len);
    end
    drv = 1'b1;
    wait_cyc(16);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int ev0;
    wait_cyc(3);
    chk(txd == 1 && !tx_busy && !tx_done && !tx_ready && !rx_valid && !rx_err && rx_data == 0,
        "R1 reset outputs", {txd, tx_busy, tx_ready, rx_valid, rx_err}, 5'b10000);
    rst_n = 1'b1;
    tx_en = 1'b1;
    wait_cyc(1);
    chk(!tx_ready && txd, "R1 state after reset", tx_ready, 0);
    wait_cyc(12);

    // R11 R2 loopback words
    send_tx(8'hA5);
    wait_cyc(20);
    send_tx(8'h00);
    wait_cyc(20);
    send_tx(8'hFF);
    wait_cyc(20);

    // R6 R7 jittered cells on the line
    drive_frame(8'h3C, 11'b000_0000_0000, 1'b1);
    drive_frame(8'h55, 11'b101_0101_0101, 1'b1);
    drive_frame(8'hC3, 11'b010_1010_1010, 1'b1);
    drive_frame(8'hFE, 11'b000_0000_0001, 1'b1);
    drive_frame(8'h81, 11'b111_0011_0110, 1'b1);

    // R9 stop bit low
    drive_frame(8'h12, 11'b000_1100_0000, 1'b0);
    chk(rx_data == 8'h81, "R9 data kept after error", rx_data, 8'h81);

    // R10 short glitch ignored
    ev0 = events;
    drv = 1'b0;
    wait_cyc(2);
    drv = 1'b1;
    wait_cyc(30);
    chk(events == ev0 && rx_data == 8'h81, "R10 glitch no output", events - ev0, 0);
    drive_frame(8'h6D, 11'b000_0000_0010, 1'b1);

    // R4 disabled transmitter
    tx_en = 1'b0;
    tx_valid = 1'b1;
    tx_data = 8'h99;
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (tx_ready || !txd || tx_busy) bad++;
      end
      chk(bad == 0, "R4 disabled: idle line, no accept", bad, 0);
    end
    tx_valid = 1'b0;

    // R3 gap after enable, then R4 abort mid-start-cell
    tx_en = 1'b1;
    begin
      int n;
      n = 0;
      while (!tx_ready && n < 40) begin
        @(negedge clk);
        n++;
      end
      chk(n == 8, "R3 gap after enable", n, 8);
    end
    ev0 = events;
    tx_valid = 1'b1;
    tx_data = 8'h42;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(!txd && tx_busy, "R2 start cell begins at accept", txd, 0);
    wait_cyc(2);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd && !tx_busy, "R4 frame dropped when disabled", {txd, tx_busy}, 2);
    wait_cyc(40);
    chk(events == ev0, "R10 aborted start gives no output", events - ev0, 0);
    tx_en = 1'b1;
    wait_cyc(12);
    send_tx(8'h7E);
    wait_cyc(30);

    chk(exp_q.size() == 0, "R6 all expected results seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule